// File: doc/BRIEF.md
# Receive Queue Steering with Hash Indirection

This block picks the final receive queue for every classified packet. Each packet brings its ingress port number, two classifier words and a 32-bit flow hash. An 8-bit queue number is built from a 5-bit upper part and a 3-bit lower part. The lower part always comes from the classifier. The upper part comes from the classifier, unless the packet's port has its override bit set; in that case a per-port upper-part register replaces it.

When the classifier asks for hash spreading, the built queue number is not final. It indexes a queue-to-table map, which names one of eight shared indirection tables. The low bits of the hash then pick an entry in that table, and the entry holds the final queue. A missing map entry or a missing table entry turns the packet into a drop. The lookup takes a fixed two cycles.

Software programs the override mask, the per-port upper parts, the map and the tables through a small register port. A select register holds the entry index, the table number and the map index. Data registers then write or read through that select.

Top module: `rss_queue_steer`

## Requirements
- R1: After reset, `out_valid` is low, the override mask and the select word read back as 0, and every map and table entry is invalid, so a packet that asks for hash spreading is dropped.
- R2: The lower three bits of the built queue are always `pkt_action[23:21]`.
- R3: When the override bit of `pkt_port` is clear, the upper five bits of the built queue are `pkt_action[28:24]`.
- R4: When bit `pkt_port` of the mask register (address 3, bits [NPORT-1:0]) is set, the upper five bits come from that port's register (address 4+port, bits [4:0]).
- R5: When `pkt_attr[30]` is 0, the output is the built queue and the packet is not dropped.
- R6: When `pkt_attr[30]` is 1, the map entry at the built queue gives a table number. The output is the entry of that table indexed by `pkt_hash[4:0]`.
- R7: When hash spreading is requested and either the map entry or the table entry is invalid, `out_drop` is 1 and `out_queue` is 0.
- R8: `out_valid` rises exactly two cycles after `pkt_valid`, once per packet, in arrival order, including back-to-back packets.
- R9: The select word (address 0) holds the table entry index in bits [7:0], the table number in bits [15:8] and the map index in bits [23:16]. A table write whose table number is 8 or more, or whose entry index is 32 or more, changes nothing, and a read through such a select returns 0.
- R10: A read on `cfg_rd` answers on the next cycle, with `cfg_rvalid` high. A table read (address 1) returns the valid bit in bit 31 and the queue in bits [7:0]. A map read (address 2) returns the valid bit in bit 31 and the table number in bits [2:0]. Writes to addresses 1 and 2 use the same layout, so writing valid=0 invalidates an entry.
- R11: A configuration write takes effect for every packet that arrives on a later cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet's lookup inputs are present |
| pkt_port | input | 2 | Ingress port number |
| pkt_action | input | 32 | Classifier action word (upper queue at [28:24], lower queue at [23:21]) |
| pkt_attr | input | 32 | Classifier attribute word (hash spreading enable at bit 30) |
| pkt_hash | input | 32 | Flow hash |
| out_valid | output | 1 | A lookup result is present |
| out_drop | output | 1 | The packet has no queue |
| out_queue | output | 8 | Final receive queue |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read response present |

## Verification
The bypass and override assertions compare the output with the per-port override registers as they stood when the packet arrived. They therefore assume that those registers are not rewritten while that packet is being looked up. The bench writes configuration only while no packet is in flight, because it sends each random packet alone and waits for its result. The back-to-back burst uses only bypass packets over unchanged settings. In the random phase, upper queue parts are kept in the range 0 to 3 and all 32 resulting queues are mapped, so that hits, map misses and entry misses all occur often.

// File: rtl/rss_steer_pkg.sv
package rss_steer_pkg;
  // classifier word field positions
  localparam int ACT_QH_LSB   = 24;
  localparam int ACT_QL_LSB   = 21;
  localparam int ATTR_RSS_BIT = 30;
  // select word layout
  localparam int SEL_FLD_W    = 8;
  localparam int SEL_ENT_LSB  = 0;
  localparam int SEL_TAB_LSB  = 8;
  localparam int SEL_MAP_LSB  = 16;
  localparam int SEL_W        = 24;
  // valid flag in data words
  localparam int DATA_VLD_BIT = 31;
  // register addresses
  localparam int CFG_SEL        = 0;
  localparam int CFG_TAB        = 1;
  localparam int CFG_MAP        = 2;
  localparam int CFG_MASK       = 3;
  localparam int CFG_HIGHQ_BASE = 4;

  typedef enum logic [1:0] {RK_REG, RK_TAB, RK_MAP} rd_kind_e;
endpackage

// File: rtl/rss_dp_ram.sv
module rss_dp_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wvld,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_data,
  output logic          a_vld,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_data,
  output logic          b_vld
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;

  // data array: no reset, synchronous reads, fits block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end

  // entry valid flags live in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      a_vld <= 1'b0;
      b_vld <= 1'b0;
    end else begin
      if (we) vld[waddr] <= wvld;
      a_vld <= vld[a_addr];
      b_vld <= vld[b_addr];
    end
  end
endmodule

// File: rtl/rss_cfg_regs.sv
module rss_cfg_regs import rss_steer_pkg::*; #(
  parameter int NPORT   = 4,
  parameter int QH_W    = 5,
  parameter int Q_W     = 8,
  parameter int NTAB    = 8,
  parameter int TAB_ENT = 32,
  parameter int DW      = 32,
  parameter int CFG_AW  = 3,
  parameter int PTR_W   = 3,
  parameter int ENT_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr,
  input  logic                         cfg_rd,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [DW-1:0]                cfg_wdata,
  output logic [DW-1:0]                cfg_rdata,
  output logic                         cfg_rvalid,
  output logic [NPORT-1:0]             ovr_mask,
  output logic [NPORT-1:0][QH_W-1:0]   ovr_high,
  output logic                         map_we,
  output logic [Q_W-1:0]               map_addr,
  output logic [PTR_W-1:0]             map_wdata,
  output logic                         map_wvld,
  input  logic [PTR_W-1:0]             map_rdata,
  input  logic                         map_rvld,
  output logic                         tab_we,
  output logic [PTR_W+ENT_W-1:0]       tab_addr,
  output logic [Q_W-1:0]               tab_wdata,
  output logic                         tab_wvld,
  input  logic [Q_W-1:0]               tab_rdata,
  input  logic                         tab_rvld
);
  logic [SEL_W-1:0]     sel;
  logic [SEL_FLD_W-1:0] sel_ent, sel_tab, sel_map;
  logic                 tab_ok;
  logic [DW-1:0]        reg_val, rd_reg;
  rd_kind_e             rd_kind;
  logic                 rd_tab_ok;

  assign sel_ent = sel[SEL_ENT_LSB +: SEL_FLD_W];
  assign sel_tab = sel[SEL_TAB_LSB +: SEL_FLD_W];
  assign sel_map = sel[SEL_MAP_LSB +: SEL_FLD_W];
  assign tab_ok  = (sel_tab < SEL_FLD_W'(NTAB)) && (sel_ent < SEL_FLD_W'(TAB_ENT));

  assign map_addr  = sel_map[Q_W-1:0];
  assign tab_addr  = {sel_tab[PTR_W-1:0], sel_ent[ENT_W-1:0]};
  assign map_we    = cfg_wr && (cfg_addr == CFG_AW'(CFG_MAP));
  assign tab_we    = cfg_wr && (cfg_addr == CFG_AW'(CFG_TAB)) && tab_ok;
  assign map_wdata = cfg_wdata[PTR_W-1:0];
  assign tab_wdata = cfg_wdata[Q_W-1:0];
  assign map_wvld  = cfg_wdata[DATA_VLD_BIT];
  assign tab_wvld  = cfg_wdata[DATA_VLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= '0;
      ovr_mask <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_AW'(CFG_SEL))  sel      <= cfg_wdata[SEL_W-1:0];
      if (cfg_addr == CFG_AW'(CFG_MASK)) ovr_mask <= cfg_wdata[NPORT-1:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_high
    always_ff @(posedge clk) begin
      if (rst) ovr_high[p] <= '0;
      else if (cfg_wr && cfg_addr == CFG_AW'(CFG_HIGHQ_BASE + p))
        ovr_high[p] <= cfg_wdata[QH_W-1:0];
    end
  end

  always_comb begin
    reg_val = '0;
    if (cfg_addr == CFG_AW'(CFG_SEL))  reg_val = DW'(sel);
    if (cfg_addr == CFG_AW'(CFG_MASK)) reg_val = DW'(ovr_mask);
    for (int p = 0; p < NPORT; p++)
      if (cfg_addr == CFG_AW'(CFG_HIGHQ_BASE + p)) reg_val = DW'(ovr_high[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rvalid <= 1'b0;
      rd_kind    <= RK_REG;
      rd_tab_ok  <= 1'b0;
      rd_reg     <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      rd_tab_ok  <= tab_ok;
      rd_reg     <= reg_val;
      if (cfg_addr == CFG_AW'(CFG_TAB))      rd_kind <= RK_TAB;
      else if (cfg_addr == CFG_AW'(CFG_MAP)) rd_kind <= RK_MAP;
      else                                   rd_kind <= RK_REG;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rvalid) begin
      case (rd_kind)
        RK_TAB: if (rd_tab_ok) begin
          cfg_rdata[Q_W-1:0]        = tab_rdata;
          cfg_rdata[DATA_VLD_BIT]   = tab_rvld;
        end
        RK_MAP: begin
          cfg_rdata[PTR_W-1:0]      = map_rdata;
          cfg_rdata[DATA_VLD_BIT]   = map_rvld;
        end
        default: cfg_rdata = rd_reg;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  // R10: every read strobe gets a response on the next cycle
  assert_read_resp_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid) else $error("read response missing");

  // R10: no response without a preceding read strobe
  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> !cfg_rvalid) else $error("spurious read response");
endmodule

// File: rtl/rss_queue_steer.sv
module rss_queue_steer import rss_steer_pkg::*; #(
  parameter int NPORT   = 4,
  parameter int QH_W    = 5,
  parameter int QL_W    = 3,
  parameter int NTAB    = 8,
  parameter int TAB_ENT = 32,
  parameter int HASH_W  = 32,
  parameter int DW      = 32
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    pkt_valid,
  input  logic [$clog2(NPORT)-1:0]                pkt_port,
  input  logic [DW-1:0]                           pkt_action,
  input  logic [DW-1:0]                           pkt_attr,
  input  logic [HASH_W-1:0]                       pkt_hash,
  output logic                                    out_valid,
  output logic                                    out_drop,
  output logic [QH_W+QL_W-1:0]                    out_queue,
  input  logic                                    cfg_wr,
  input  logic                                    cfg_rd,
  input  logic [$clog2(CFG_HIGHQ_BASE+NPORT)-1:0] cfg_addr,
  input  logic [DW-1:0]                           cfg_wdata,
  output logic [DW-1:0]                           cfg_rdata,
  output logic                                    cfg_rvalid
);
  localparam int Q_W    = QH_W + QL_W;
  localparam int PTR_W  = $clog2(NTAB);
  localparam int ENT_W  = $clog2(TAB_ENT);
  localparam int TA_W   = PTR_W + ENT_W;
  localparam int CFG_AW = $clog2(CFG_HIGHQ_BASE + NPORT);

  logic [NPORT-1:0]           ovr_mask;
  logic [NPORT-1:0][QH_W-1:0] ovr_high;
  logic                       map_we, map_wvld, map_bvld, map_avld;
  logic [Q_W-1:0]             map_caddr;
  logic [PTR_W-1:0]           map_wdata, map_bdata, map_adata;
  logic                       tab_we, tab_wvld, tab_bvld, tab_avld;
  logic [TA_W-1:0]            tab_caddr;
  logic [Q_W-1:0]             tab_wdata, tab_bdata, tab_adata;

  rss_cfg_regs #(
    .NPORT(NPORT), .QH_W(QH_W), .Q_W(Q_W), .NTAB(NTAB), .TAB_ENT(TAB_ENT),
    .DW(DW), .CFG_AW(CFG_AW), .PTR_W(PTR_W), .ENT_W(ENT_W)
  ) i_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .ovr_mask(ovr_mask), .ovr_high(ovr_high),
    .map_we(map_we), .map_addr(map_caddr), .map_wdata(map_wdata), .map_wvld(map_wvld),
    .map_rdata(map_bdata), .map_rvld(map_bvld),
    .tab_we(tab_we), .tab_addr(tab_caddr), .tab_wdata(tab_wdata), .tab_wvld(tab_wvld),
    .tab_rdata(tab_bdata), .tab_rvld(tab_bvld)
  );

  // stage 0: build the queue from classifier fields and port override
  logic [QH_W-1:0] qh_sel;
  logic [Q_W-1:0]  q_built;
  assign qh_sel  = ovr_mask[pkt_port] ? ovr_high[pkt_port]
                                      : pkt_action[ACT_QH_LSB +: QH_W];
  assign q_built = {qh_sel, pkt_action[ACT_QL_LSB +: QL_W]};

  logic             s1_valid, s1_rss;
  logic [Q_W-1:0]   s1_q;
  logic [ENT_W-1:0] s1_ent;
  logic             s2_valid, s2_rss, s2_map_ok;
  logic [Q_W-1:0]   s2_q;

  rss_dp_ram #(.DW(PTR_W), .AW(Q_W)) i_map (
    .clk(clk), .rst(rst), .we(map_we), .waddr(map_caddr), .wdata(map_wdata),
    .wvld(map_wvld), .a_addr(q_built), .a_data(map_adata), .a_vld(map_avld),
    .b_addr(map_caddr), .b_data(map_bdata), .b_vld(map_bvld)
  );

  rss_dp_ram #(.DW(Q_W), .AW(TA_W)) i_tab (
    .clk(clk), .rst(rst), .we(tab_we), .waddr(tab_caddr), .wdata(tab_wdata),
    .wvld(tab_wvld), .a_addr({map_adata, s1_ent}), .a_data(tab_adata),
    .a_vld(tab_avld), .b_addr(tab_caddr), .b_data(tab_bdata), .b_vld(tab_bvld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_rss    <= 1'b0;
      s1_q      <= '0;
      s1_ent    <= '0;
      s2_valid  <= 1'b0;
      s2_rss    <= 1'b0;
      s2_map_ok <= 1'b0;
      s2_q      <= '0;
    end else begin
      s1_valid  <= pkt_valid;
      s1_rss    <= pkt_attr[ATTR_RSS_BIT];
      s1_q      <= q_built;
      s1_ent    <= pkt_hash[ENT_W-1:0];
      s2_valid  <= s1_valid;
      s2_rss    <= s1_rss;
      s2_map_ok <= map_avld;
      s2_q      <= s1_q;
    end
  end

  // stage 2: pick the bypass queue or the table entry
  always_comb begin
    out_valid = s2_valid;
    out_drop  = s2_valid && s2_rss && !(s2_map_ok && tab_avld);
    if (!s2_rss)      out_queue = s2_q;
    else if (out_drop) out_queue = '0;
    else              out_queue = tab_adata;
  end

  logic unused_in;
  assign unused_in = ^{pkt_hash, pkt_attr, pkt_action};

  // R8: fixed two-cycle latency
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> ##2 out_valid) else $error("result missing");
  assert_no_extra_R8: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> ##2 !out_valid) else $error("result without packet");

  // R2 and R5: bypass packets keep the classifier low part and are never dropped
  assert_bypass_qlow_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_attr[ATTR_RSS_BIT] |-> ##2
      (!out_drop && out_queue[QL_W-1:0] == $past(pkt_action[ACT_QL_LSB +: QL_W], 2)))
    else $error("bypass result wrong");

  // R4: override supplies the upper part
  assert_override_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && ovr_mask[pkt_port] && !pkt_attr[ATTR_RSS_BIT] |-> ##2
      (out_queue[Q_W-1:QL_W] == $past(ovr_high[pkt_port], 2)))
    else $error("override not applied");

  // R7: a dropped packet carries queue 0
  assert_drop_zero_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_drop |-> out_queue == '0) else $error("drop with queue");
endmodule

// File: tb/test_rss_queue_steer.sv
module test_rss_queue_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic [1:0]  pkt_port = '0;
  logic [31:0] pkt_action = '0, pkt_attr = '0, pkt_hash = '0;
  logic        out_valid, out_drop;
  logic [7:0]  out_queue;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;

  always #5 clk = ~clk;

  rss_queue_steer i_rss_queue_steer (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_port(pkt_port),
    .pkt_action(pkt_action), .pkt_attr(pkt_attr), .pkt_hash(pkt_hash),
    .out_valid(out_valid), .out_drop(out_drop), .out_queue(out_queue),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit [3:0]      m_mask;
  bit [4:0]      m_high [4];
  bit            m_v [256];
  bit [2:0]      m_p [256];
  bit            t_v [8][32];
  bit [7:0]      t_q [8][32];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(bit [1:0] port, bit [4:0] qh, bit [2:0] ql,
                                        bit rss, bit [31:0] hash);
    bit [7:0] q;
    bit [2:0] p;
    q = {(m_mask[port] ? m_high[port] : qh), ql};
    if (!rss) return {1'b0, q};
    if (!m_v[q]) return 9'h100;
    p = m_p[q];
    if (!t_v[p][hash[4:0]]) return 9'h100;
    return {1'b0, t_q[p][hash[4:0]]};
  endfunction

  task automatic wr(bit [2:0] a, bit [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, bit [2:0] a, bit [31:0] exp);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(req, {cfg_rvalid, cfg_rdata[30:0]}, {1'b1, exp[30:0]});
    chk(req, {31'b0, cfg_rdata[31]}, {31'b0, exp[31]});
  endtask

  task automatic set_sel(int t, int e, int q);
    wr(3'd0, ((q & 255) << 16) | ((t & 255) << 8) | (e & 255));
  endtask

  task automatic set_tab(int t, int e, bit [7:0] q, bit v);
    set_sel(t, e, 0);
    wr(3'd1, {v, 23'b0, q});
    if (t < 8 && e < 32) begin t_v[t][e] = v; t_q[t][e] = q; end
  endtask

  task automatic set_map(int q, bit [2:0] p, bit v);
    set_sel(0, 0, q);
    wr(3'd2, {v, 28'b0, p});
    m_v[q] = v; m_p[q] = p;
  endtask

  task automatic set_mask(bit [3:0] m);
    wr(3'd3, {28'b0, m}); m_mask = m;
  endtask

  task automatic set_high(int port, bit [4:0] h);
    wr(3'(4 + port), {27'b0, h}); m_high[port] = h;
  endtask

  task automatic drive(bit [1:0] port, bit [4:0] qh, bit [2:0] ql, bit rss, bit [31:0] hash);
    pkt_valid  = 1'b1;
    pkt_port   = port;
    pkt_action = {3'($urandom), qh, ql, 21'($urandom)};
    pkt_attr   = {1'b0, rss, 30'($urandom)};
    pkt_hash   = hash;
  endtask

  task automatic send(string req, bit [1:0] port, bit [4:0] qh, bit [2:0] ql,
                      bit rss, bit [31:0] hash);
    logic [8:0] e;
    e = model(port, qh, ql, rss, hash);
    drive(port, qh, ql, rss, hash);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(req, {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk(req, {22'b0, out_valid, out_drop, out_queue}, {22'b0, 1'b1, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] be [3];
    void'($urandom(32'd20240517));
    m_mask = '0;
    for (int i = 0; i < 4; i++) m_high[i] = '0;
    for (int i = 0; i < 256; i++) begin m_v[i] = 1'b0; m_p[i] = '0; end
    for (int t = 0; t < 8; t++)
      for (int e = 0; e < 32; e++) begin t_v[t][e] = 1'b0; t_q[t][e] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    rd_chk("R1 mask after reset", 3'd3, 32'd0);
    rd_chk("R1 select after reset", 3'd0, 32'd0);
    rd_chk("R1 table entry invalid after reset", 3'd1, 32'd0);
    send("R1 spreading packet dropped after reset", 2'd0, 5'd0, 3'd0, 1'b1, 32'h0);

    // R3 and R5: classifier upper part, bypass
    send("R3 classifier upper part", 2'd2, 5'd7, 3'd5, 1'b0, 32'h1234);

    // R4: port 1 override to 4 gives queue 32+low
    set_high(1, 5'd4);
    set_mask(4'b0010);
    send("R4 override upper part", 2'd1, 5'd0, 3'd1, 1'b0, 32'h0);
    send("R3 other port not overridden", 2'd0, 5'd2, 3'd6, 1'b0, 32'h0);
    send("R2 low part kept under override", 2'd1, 5'd31, 3'd7, 1'b0, 32'h0);

    // R6 and R11: program map and table, packet on the very next cycle
    set_map(33, 3'd1, 1'b1);
    set_tab(1, 5, 8'h21, 1'b1);
    send("R6 R11 spread lookup after write", 2'd1, 5'd0, 3'd1, 1'b1, 32'hABCDE5);

    // R7: entry and map misses
    send("R7 table entry invalid", 2'd1, 5'd0, 3'd1, 1'b1, 32'hABCDE6);
    send("R7 map entry invalid", 2'd1, 5'd0, 3'd2, 1'b1, 32'hABCDE5);

    // R10: readback layout
    set_sel(1, 5, 33);
    rd_chk("R10 table readback", 3'd1, 32'h8000_0021);
    rd_chk("R10 map readback", 3'd2, 32'h8000_0001);
    rd_chk("R9 select readback", 3'd0, 32'h0021_0105);
    rd_chk("R10 high part readback", 3'd5, 32'd4);

    // R9: out of range table writes ignored
    set_tab(8, 0, 8'h55, 1'b1);
    rd_chk("R9 table number out of range reads 0", 3'd1, 32'd0);
    set_tab(1, 32, 8'h66, 1'b1);
    rd_chk("R9 entry out of range reads 0", 3'd1, 32'd0);
    set_sel(1, 0, 0);
    rd_chk("R9 entry 0 untouched", 3'd1, 32'd0);
    set_sel(0, 0, 0);
    rd_chk("R9 table 0 untouched", 3'd1, 32'd0);
    send("R9 aliased entry still invalid", 2'd1, 5'd0, 3'd1, 1'b1, 32'h20);

    // R10 and R7: writing valid=0 invalidates
    set_tab(1, 5, 8'h21, 1'b0);
    send("R7 invalidated entry drops", 2'd1, 5'd0, 3'd1, 1'b1, 32'h5);

    // R8: back-to-back burst of bypass packets
    for (int i = 0; i < 6; i++) begin
      if (i >= 2 && i < 5)
        chk("R8 burst order", {22'b0, out_valid, out_drop, out_queue}, {22'b0, 1'b1, be[i-2]});
      if (i == 5)
        chk("R8 no extra result", {31'b0, out_valid}, 32'd0);
      if (i < 3) begin
        be[i] = model(2'(i), 5'(i + 9), 3'(i + 3), 1'b0, 32'h0);
        drive(2'(i), 5'(i + 9), 3'(i + 3), 1'b0, 32'h0);
      end else pkt_valid = 1'b0;
      @(negedge clk);
    end

    // random phase
    set_mask(4'($urandom));
    for (int p = 0; p < 4; p++) set_high(p, 5'($urandom % 4));
    for (int q = 0; q < 32; q++) set_map(q, 3'($urandom), ($urandom % 4) != 0);
    for (int k = 0; k < 160; k++)
      set_tab($urandom % 8, $urandom % 32, 8'($urandom), ($urandom % 4) != 0);
    for (int k = 0; k < 300; k++)
      send("R6 R2 R3 R4 random packet", 2'($urandom), 5'($urandom % 4), 3'($urandom),
           1'($urandom), $urandom);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule